// File: doc/BRIEF.md
# Synthesizer Control and Status Serial Slave

This block is a two-wire serial (I2C) slave that holds the configuration of a frequency synthesizer and reports its status. A bus master writes an address byte followed by up to four control bytes; these program the 17-bit main divider ratio, a 3-bit reference ratio code, a 2-bit charge pump current code, the prescaler enable, the reference output select, a 2-bit test mode and four port output bits. A read returns one status byte with three port input levels, a 3-bit converter code, the lock flag and a power-on flag.

SCL and SDA are sampled by the system clock, synchronized, and accepted only after several consecutive equal samples, so both standard and fast bus rates work with a fast system clock. SDA is open-drain: the block pulls the line low through `sda_oe`. Two strap inputs pick one of four slave addresses, so several synthesizers can share one bus. Written values go to a shadow set and reach the outputs only at the STOP condition.

Top module: `synctl_slave`

## Requirements
- R1: The slave answers only the 7-bit address {1,1,0,0,0,addr_sel[1],addr_sel[0]} (R/W in bit 0 of the address byte, 0 = write); any other address gets no ACK, and the transfer changes no output.
- R2: After a matching address byte and after every data byte of a write, the slave pulls SDA low for the ACK bit; `sda_oe` changes only after a filtered SCL falling edge, a START or a STOP.
- R3: A data byte with bit 7 = 0 loads divider bits 14:8 from its bits 6:0, and the next data byte loads divider bits 7:0.
- R4: A data byte with bit 7 = 1 (not following an R3 byte) sets divider bit 16 from bit 6, divider bit 15 from bit 5, the charge pump code from bits 4:3 and the reference code from bits 2:0.
- R5: The data byte after an R4 byte sets prescaler enable from bit 7, output select from bit 6, test mode from bits 5:4 and port outputs from bits 3:0.
- R6: No configuration output changes before the STOP that ends the write; at that STOP all written fields take effect together.
- R7: A read returns the status byte {por, lock_in, port_in[2:0], adc_code[2:0]}, MSB first.
- R8: The power-on flag is 1 after reset and is 0 in every status byte read after a first status byte has been completely read.
- R9: After reset all configuration outputs are 0 and SDA is released.
- R10: Fields whose bytes are not sent in a write keep their previous values.
- R11: SCL or SDA pulses shorter than the filter length (3 system clocks) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Address strap, low two address bits |
| port_in | input | 3 | Port input levels for status |
| adc_code | input | 3 | Converter result for status |
| lock_in | input | 1 | Loop lock indication |
| div_ratio | output | 17 | Main divider ratio |
| ref_code | output | 3 | Reference ratio code |
| cp_code | output | 2 | Charge pump current code |
| presc_en | output | 1 | Divide-by-two prescaler enable |
| xo_sel | output | 1 | Reference output select |
| test_mode | output | 2 | Test mode code |
| port_out | output | 4 | Port output bits |

## Verification
The bench probes the outputs between the last data byte and the STOP: a design that commits each byte on arrival would show the new divider early. It writes only the control byte pair after a full write, so a design that clears untouched fields would lose the divider it had. Reading status twice catches a power-on flag that never clears or clears at the address phase, and a short SCL spike inside a data byte catches a filter that lets a two-cycle pulse count as a bit and shifts the divider. A strap change with the old address reused catches a hard-wired address.

// File: rtl/synctl_pkg.sv
package synctl_pkg;
  localparam int DIV_W  = 17;
  localparam int REF_W  = 3;
  localparam int CP_W   = 2;
  localparam int TM_W   = 2;
  localparam int PORT_N = 4;
  localparam int PIN_N  = 3;
  localparam int ADC_W  = 3;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } link_st_t;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [REF_W-1:0]  refc;
    logic [CP_W-1:0]   cp;
    logic              presc;
    logic              xo;
    logic [TM_W-1:0]   tm;
    logic [PORT_N-1:0] port;
  } cfg_t;
endpackage

// File: rtl/synctl_filt.sv
module synctl_filt #(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt,
  output logic rise,
  output logic fall
);
  logic [SYNC_N-1:0] sync;
  logic [FILT_N-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= '1;
      hist <= '1;
      filt <= 1'b1;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      sync <= {sync[SYNC_N-2:0], raw};
      hist <= {hist[FILT_N-2:0], sync[SYNC_N-1]};
      rise <= 1'b0;
      fall <= 1'b0;
      if (hist == '1 && !filt) begin
        filt <= 1'b1;
        rise <= 1'b1;
      end else if (hist == '0 && filt) begin
        filt <= 1'b0;
        fall <= 1'b1;
      end
    end
  end

  // R11: the filtered level moves only to a value the oldest and newest history agreed on
  a_r11_filter_agree: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> ($past(hist[0]) == filt && $past(hist[FILT_N-1]) == filt));
endmodule

// File: rtl/synctl_link.sv
module synctl_link
  import synctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_f,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       start_p,
  output logic       stop_p,
  output logic       wr_begin,
  output logic       wr_vld,
  output logic [7:0] wr_byte,
  output logic       rd_done
);
  link_st_t   st;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rw;
  logic       ack_m;

  assign start_p = sda_fall && scl_f;
  assign stop_p  = sda_rise && scl_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      sh       <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      ack_m    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_begin <= 1'b0;
      wr_vld   <= 1'b0;
      wr_byte  <= '0;
      rd_done  <= 1'b0;
    end else begin
      wr_begin <= 1'b0;
      wr_vld   <= 1'b0;
      rd_done  <= 1'b0;
      if (start_p) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_WDAT) begin
                wr_vld  <= 1'b1;
                wr_byte <= sh;
                sda_oe  <= 1'b1;
                st      <= S_WACK;
              end else if (sh[7:1] == {ADDR_FIXED, addr_sel}) begin
                rw       <= sh[0];
                wr_begin <= !sh[0];
                sda_oe   <= 1'b1;
                st       <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st     <= S_RDAT;
              sh     <= status_byte;
              sda_oe <= !status_byte[7];
            end else begin
              st     <= S_WDAT;
              sda_oe <= 1'b0;
            end
          end
          S_WACK: if (scl_fall) begin
            st     <= S_WDAT;
            cnt    <= '0;
            sda_oe <= 1'b0;
          end
          S_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= !sh[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              rd_done <= 1'b1;
              ack_m   <= !sda_f;
            end else if (scl_fall) begin
              if (ack_m) begin
                st     <= S_RDAT;
                cnt    <= '0;
                sh     <= status_byte;
                sda_oe <= !status_byte[7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2: SDA drive changes only after an SCL fall or a bus condition
  a_r2_oe_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_p || stop_p));
  // R1: an idle slave never holds SDA
  a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe);
endmodule

// File: rtl/synctl_slave.sv
module synctl_slave
  import synctl_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int FILT_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic [PIN_N-1:0]  port_in,
  input  logic [ADC_W-1:0]  adc_code,
  input  logic              lock_in,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [REF_W-1:0]  ref_code,
  output logic [CP_W-1:0]   cp_code,
  output logic              presc_en,
  output logic              xo_sel,
  output logic [TM_W-1:0]   test_mode,
  output logic [PORT_N-1:0] port_out
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, up, dn;
  logic start_p, stop_p, wr_begin, wr_vld, rd_done;
  logic [7:0] wr_byte, status_q;
  logic por_q, want_low, want_b, dirty;
  cfg_t act_q, shd_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    synctl_filt #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_filt (
      .clk(clk), .rst(rst), .raw(raw[g]),
      .filt(lvl[g]), .rise(up[g]), .fall(dn[g]));
  end

  synctl_link u_link (
    .clk(clk), .rst(rst),
    .scl_f(lvl[0]), .scl_rise(up[0]), .scl_fall(dn[0]),
    .sda_f(lvl[1]), .sda_rise(up[1]), .sda_fall(dn[1]),
    .addr_sel(addr_sel), .status_byte(status_q),
    .sda_oe(sda_oe), .start_p(start_p), .stop_p(stop_p),
    .wr_begin(wr_begin), .wr_vld(wr_vld), .wr_byte(wr_byte),
    .rd_done(rd_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      por_q    <= 1'b1;
    end else begin
      status_q <= {por_q, lock_in, port_in, adc_code};
      if (rd_done) por_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= '0;
      shd_q    <= '0;
      want_low <= 1'b0;
      want_b   <= 1'b0;
      dirty    <= 1'b0;
    end else begin
      if (wr_begin) begin
        want_low <= 1'b0;
        want_b   <= 1'b0;
        if (!dirty) shd_q <= act_q;
      end else if (wr_vld) begin
        dirty <= 1'b1;
        if (want_low) begin
          shd_q.div[7:0] <= wr_byte;
          want_low       <= 1'b0;
        end else if (want_b) begin
          {shd_q.presc, shd_q.xo, shd_q.tm, shd_q.port} <= wr_byte;
          want_b <= 1'b0;
        end else if (!wr_byte[7]) begin
          shd_q.div[14:8] <= wr_byte[6:0];
          want_low        <= 1'b1;
        end else begin
          {shd_q.div[16], shd_q.div[15], shd_q.cp, shd_q.refc} <= wr_byte[6:0];
          want_b <= 1'b1;
        end
      end
      if (stop_p && dirty) begin
        act_q <= shd_q;
        dirty <= 1'b0;
      end
    end
  end

  assign div_ratio = act_q.div;
  assign ref_code  = act_q.refc;
  assign cp_code   = act_q.cp;
  assign presc_en  = act_q.presc;
  assign xo_sel    = act_q.xo;
  assign test_mode = act_q.tm;
  assign port_out  = act_q.port;

  // R6: configuration moves only on the cycle after a STOP
  a_r6_commit_at_stop: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(stop_p));
  // R8: the power-on flag drops only after a status byte was acknowledged or refused
  a_r8_por_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(por_q) |-> $past(rd_done));
endmodule

// File: tb/test_synctl_slave.sv
module test_synctl_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_i;
  logic [1:0] addr_sel = 2'b10;
  logic [2:0] port_in = '0, adc_code = '0;
  logic lock_in = 1'b0;
  logic [16:0] div_ratio;
  logic [2:0] ref_code;
  logic [1:0] cp_code, test_mode;
  logic presc_en, xo_sel;
  logic [3:0] port_out;

  int checks = 0, errors = 0;
  logic last_ack;
  logic [7:0] last_rd;
  bit done = 0;

  typedef struct {string req; int sel; logic [31:0] exp;} item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;
  assign sda_i = m_sda & ~sda_oe;

  synctl_slave i_synctl_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_i), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .port_in(port_in), .adc_code(adc_code),
    .lock_in(lock_in), .div_ratio(div_ratio), .ref_code(ref_code),
    .cp_code(cp_code), .presc_en(presc_en), .xo_sel(xo_sel),
    .test_mode(test_mode), .port_out(port_out));

  function automatic logic [31:0] actual(int sel);
    case (sel)
      0: return 32'(div_ratio);
      1: return 32'(ref_code);
      2: return 32'(cp_code);
      3: return 32'(presc_en);
      4: return 32'(xo_sel);
      5: return 32'(test_mode);
      6: return 32'(port_out);
      7: return 32'(last_ack);
      8: return 32'(last_rd);
      default: return 32'(sda_oe);
    endcase
  endfunction

  task automatic expect_item(string req, int sel, logic [31:0] e);
    item_t it;
    it.req = req; it.sel = sel; it.exp = e;
    exp_q.push_back(it);
  endtask

  // monitor: pops expected items and compares with the observed values
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] a;
        it = exp_q.pop_front();
        a = actual(it.sel);
        checks++;
        if (a !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, a, it.exp);
        end
      end
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1; m_scl = 1; wt(Q);
    m_sda = 0; wt(Q);
    m_scl = 0; wt(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; wt(Q);
    m_scl = 1; wt(Q);
    m_sda = 1; wt(Q);
  endtask

  task automatic wr_bit(logic b, bit glitch);
    m_sda = b; wt(Q / 2);
    if (glitch) begin
      m_scl = 1; wt(2); m_scl = 0;
    end
    wt(Q);
    m_scl = 1; wt(2 * Q);
    m_scl = 0; wt(Q);
  endtask

  task automatic rd_bit(output logic b);
    m_sda = 1; wt(Q);
    m_scl = 1; wt(Q);
    b = sda_i; wt(Q);
    m_scl = 0; wt(Q);
  endtask

  task automatic wr_byte(logic [7:0] d, bit glitch = 0);
    logic a;
    for (int i = 7; i >= 0; i--) wr_bit(d[i], glitch && i == 4);
    rd_bit(a);
    last_ack = !a;
  endtask

  task automatic rd_byte(bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      last_rd[i] = b;
    end
    wr_bit(!ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wt(5);
    rst = 0;
    wt(5);
    // R9: reset state
    expect_item("R9 div", 0, 0);
    expect_item("R9 port", 6, 0);
    expect_item("R9 cp", 2, 0);
    expect_item("R9 sda released", 9, 0);
    wt(2);

    // full write at strap 10 -> address byte 0xC4
    i2c_start();
    wr_byte(8'hC4); expect_item("R2 addr ack", 7, 1);
    wr_byte(8'h12); expect_item("R2 data ack", 7, 1);
    wr_byte(8'h34);
    wr_byte(8'hD5);
    wr_byte(8'h9A); expect_item("R2 last ack", 7, 1);
    wt(2);
    expect_item("R6 div held before stop", 0, 0);
    expect_item("R6 port held before stop", 6, 0);
    wt(2);
    i2c_stop(); wt(4);
    expect_item("R3 R4 div", 0, 32'h11234);
    expect_item("R4 ref", 1, 5);
    expect_item("R4 cp", 2, 2);
    expect_item("R5 presc", 3, 1);
    expect_item("R5 xo", 4, 0);
    expect_item("R5 test", 5, 1);
    expect_item("R5 port", 6, 4'hA);
    wt(2);

    // wrong address
    i2c_start();
    wr_byte(8'hC0); expect_item("R1 foreign addr nack", 7, 0);
    wt(2);
    i2c_stop(); wt(4);
    expect_item("R1 div unchanged", 0, 32'h11234);
    wt(2);

    // partial write: control pair only
    i2c_start();
    wr_byte(8'hC4);
    wr_byte(8'hAB);
    wr_byte(8'h4F);
    i2c_stop(); wt(4);
    expect_item("R10 div low bits kept", 0, 32'h09234);
    expect_item("R4 cp second", 2, 1);
    expect_item("R4 ref second", 1, 3);
    expect_item("R5 port second", 6, 4'hF);
    expect_item("R5 xo second", 4, 1);
    expect_item("R5 presc second", 3, 0);
    wt(2);

    // status reads
    port_in = 3'b101; adc_code = 3'b011; lock_in = 1;
    i2c_start();
    wr_byte(8'hC5); expect_item("R2 read addr ack", 7, 1);
    rd_byte(0);
    i2c_stop(); wt(2);
    expect_item("R7 R8 first status", 8, 8'hEB);
    wt(2);
    i2c_start();
    wr_byte(8'hC5);
    rd_byte(0);
    i2c_stop(); wt(2);
    expect_item("R8 por cleared", 8, 8'h6B);
    wt(2);
    port_in = 3'b010; adc_code = 3'b110; lock_in = 0;
    i2c_start();
    wr_byte(8'hC5);
    rd_byte(0);
    i2c_stop(); wt(2);
    expect_item("R7 status fields", 8, 8'h16);
    wt(2);

    // SCL spike inside a data byte
    i2c_start();
    wr_byte(8'hC4);
    wr_byte(8'h05, 1); expect_item("R11 ack after spike", 7, 1);
    wr_byte(8'h66);
    i2c_stop(); wt(4);
    expect_item("R11 div after spike", 0, 32'h08566);
    wt(2);

    // strap change
    addr_sel = 2'b01;
    i2c_start();
    wr_byte(8'hC4); expect_item("R1 old address refused", 7, 0);
    i2c_stop(); wt(2);
    i2c_start();
    wr_byte(8'hC2); expect_item("R1 new address ack", 7, 1);
    wr_byte(8'h7F);
    wr_byte(8'hFF);
    i2c_stop(); wt(4);
    expect_item("R1 R3 div new strap", 0, 32'h0FFFF);
    wt(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule